// File: doc/BRIEF.md
# Masked Vector Lane Compactor

This unit takes a source vector of N lanes, each W bits wide, together with an N-bit predicate mask that has one bit per lane. It produces a result vector in which every lane whose mask bit is 1 is moved toward lane 0 and packed without gaps. The packed lanes keep the order they had in the source, and every destination lane after the last packed one is cleared to zero. The unit also reports how many lanes survived. Producing the result is its only effect.

A source lane i goes to destination slot p(i). p(i) is the number of set mask bits below position i, which is an exclusive prefix popcount. Each destination slot takes the one source lane whose prefix count equals the slot index. If no source lane matches, the slot is zero. The packed vector and its lane count are captured in a one-entry output register.

Operands arrive over a valid/ready handshake, and the result leaves over a second valid/ready handshake. The output register is run by a two-state machine:

- ST_EMPTY means no result is held.
- ST_FULL means a result is held.

The machine has four transitions:

- LOAD: ST_EMPTY to ST_FULL when an operand is accepted.
- HOLD: ST_FULL stays in ST_FULL while the consumer stalls.
- REFILL: ST_FULL stays in ST_FULL when one result drains and a new operand is accepted in the same cycle.
- DRAIN: ST_FULL to ST_EMPTY when a result drains and no operand arrives.

Top module: `lane_compactor`

## Requirements
- R1: A source lane appears in the result only if its mask bit (bit i of `in_mask` for lane i, with lane i at `in_data[i*W +: W]`) is 1. Lanes whose mask bit is 0 are dropped.
- R2: The surviving lanes keep their source order. A kept lane with a lower source index lands at a lower destination index.
- R3: The surviving lanes occupy destination lanes 0 up to count-1, with no gaps.
- R4: Every destination lane at index count or above is all zeros.
- R5: `out_count` equals the number of 1 bits in the accepted mask. It is clog2(N+1) bits wide.
- R6: When an operand is accepted (`in_valid` and `in_ready` high at a rising edge), its result appears with `out_valid` high right after that same edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_count` stay unchanged at the next edge.
- R8: `in_ready` is high exactly when no result is held or `out_ready` is high. This allows one vector per cycle with no bubbles.
- R9: An all-zero mask gives an all-zero vector and count 0. An all-ones mask returns the source unchanged with count N.
- R10: While `rst_n` is low, `out_valid` is 0 and `out_data` and `out_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | N*W | Source vector, lane i at bits i*W +: W |
| in_mask | input | N | Keep bit per lane |
| out_valid | output | 1 | Packed result held |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | N*W | Packed vector with zero tail |
| out_count | output | clog2(N+1) | Number of kept lanes |

## Verification
A bad prefix count or a bad scatter select puts a lane in the wrong slot, duplicates a lane, or leaves a nonzero tail. Any of these shows on `out_data` in the first cycle the affected result is valid, which is one edge after acceptance. A state register that sticks in ST_FULL or ST_EMPTY shows one edge later in two ways: `out_valid` disagrees with the handshake history, and `in_ready` is wrong under a stalled consumer. A result lost or overwritten while ST_FULL holds it shows as changed data during the stall.

// File: rtl/lc_pkg.sv
package lc_pkg;

    // Occupancy of the single result register
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } lc_state_e;

endpackage

// File: rtl/lc_prefix_count.sv
// Exclusive prefix popcount of the mask plus its total.
module lc_prefix_count #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]    mask,
    output logic [N*CW-1:0] pfx_flat,
    output logic [CW-1:0]   total
);

    logic [CW-1:0] run [N+1];

    assign run[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign run[i+1]                = run[i] + CW'(mask[i]);
        assign pfx_flat[i*CW +: CW]    = run[i];
    end

    assign total = run[N];

endmodule

// File: rtl/lc_scatter.sv
// Each destination slot picks the kept source lane whose prefix equals its index.
module lc_scatter #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N*W-1:0]  src,
    input  logic [N-1:0]    mask,
    input  logic [N*CW-1:0] pfx_flat,
    output logic [N*W-1:0]  dst
);

    for (genvar j = 0; j < N; j++) begin : g_slot
        logic [W-1:0] acc;

        always_comb begin
            acc = '0;
            for (int i = j; i < N; i++) begin
                if (mask[i] && (pfx_flat[i*CW +: CW] == CW'(j))) begin
                    acc = acc | src[i*W +: W];
                end
            end
        end

        assign dst[j*W +: W] = acc;
    end

endmodule

// File: rtl/lc_out_stage.sv
// One-entry result register driven by a two-state occupancy machine.
module lc_out_stage
    import lc_pkg::*;
#(
    parameter int DW = 128,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_valid,
    input  logic [DW-1:0] load_data,
    input  logic [CW-1:0] load_count,
    output logic          load_ready,
    input  logic          sink_ready,
    output logic          held_valid,
    output logic [DW-1:0] held_data,
    output logic [CW-1:0] held_count
);

    lc_state_e st_q, st_d;
    logic      take;

    assign load_ready = (st_q == ST_EMPTY) || sink_ready;
    assign take       = load_valid && load_ready;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (take) st_d = ST_FULL;             // LOAD
            ST_FULL: begin
                if (take)            st_d = ST_FULL;        // REFILL
                else if (sink_ready) st_d = ST_EMPTY;       // DRAIN
                else                 st_d = ST_FULL;        // HOLD
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_data  <= '0;
            held_count <= '0;
        end else if (take) begin
            held_data  <= load_data;
            held_count <= load_count;
        end
    end

    assign held_valid = (st_q == ST_FULL);

endmodule

// File: rtl/lane_compactor.sv
module lane_compactor #(
    parameter int N  = 8,
    parameter int W  = 16,
    localparam int DW = N * W,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic [N-1:0]  in_mask,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [CW-1:0] out_count
);

    logic [N*CW-1:0] pfx_flat;
    logic [CW-1:0]   kept;
    logic [DW-1:0]   packed_vec;

    lc_prefix_count #(.N(N), .CW(CW)) u_pfx (
        .mask     (in_mask),
        .pfx_flat (pfx_flat),
        .total    (kept)
    );

    lc_scatter #(.N(N), .W(W), .CW(CW)) u_scatter (
        .src      (in_data),
        .mask     (in_mask),
        .pfx_flat (pfx_flat),
        .dst      (packed_vec)
    );

    lc_out_stage #(.DW(DW), .CW(CW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (in_valid),
        .load_data  (packed_vec),
        .load_count (kept),
        .load_ready (in_ready),
        .sink_ready (out_ready),
        .held_valid (out_valid),
        .held_data  (out_data),
        .held_count (out_count)
    );

endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [N-1:0]   in_mask,
    input logic           out_valid,
    input logic           out_ready,
    input logic [N*W-1:0] out_data,
    input logic [CW-1:0]  out_count
);

    logic tail_dirty;

    always_comb begin
        tail_dirty = 1'b0;
        for (int j = 0; j < N; j++) begin
            if ((j >= int'(out_count)) && (out_data[j*W +: W] != '0)) tail_dirty = 1'b1;
        end
    end

    // R4
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !tail_dirty);

    // R5
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (int'(out_count) == $countones($past(in_mask))));

    // R6
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_count)));

    // R8
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_count == '0));

endmodule

bind lane_compactor lc_checker #(.N(N), .W(W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mask   (in_mask),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_count (out_count)
);

// File: tb/tb_lane_compactor.sv
`timescale 1ns/1ps
module tb_lane_compactor;

    localparam int N  = 8;
    localparam int W  = 16;
    localparam int DW = N * W;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic [N-1:0]  in_mask = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic [CW-1:0] out_count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    bit          ev = 1'b0;
    logic [DW-1:0] ed = '0;
    int          ec = 0;

    always #5 clk = ~clk;

    lane_compactor #(.N(N), .W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_mask(in_mask),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_count(out_count)
    );

    function automatic logic [DW-1:0] ref_pack(input logic [DW-1:0] d, input logic [N-1:0] m);
        logic [W-1:0] q[$];
        logic [DW-1:0] r = '0;
        for (int i = 0; i < N; i++) if (m[i]) q.push_back(d[i*W +: W]);
        for (int j = 0; j < q.size(); j++) r[j*W +: W] = q[j];
        return r;
    endfunction

    function automatic int ref_pop(input logic [N-1:0] m);
        int c = 0;
        for (int i = 0; i < N; i++) if (m[i]) c++;
        return c;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", what, act, exp, $time);
        end
    endtask

    task automatic step(input string note, input logic v, input logic [DW-1:0] d,
                        input logic [N-1:0] m, input logic ordy);
        bit fire;
        @(negedge clk);
        in_valid = v; in_data = d; in_mask = m; out_ready = ordy;
        #1;
        chk(out_valid == ev, {note, " R6 R7 out_valid"}, DW'(out_valid), DW'(ev));
        if (ev) begin
            chk(out_data == ed, {note, " R1 R2 R3 R4 out_data"}, out_data, ed);
            chk(int'(out_count) == ec, {note, " R5 out_count"}, DW'(out_count), DW'(ec));
        end
        chk(in_ready == (!ev || ordy), {note, " R8 in_ready"}, DW'(in_ready), DW'(!ev || ordy));
        fire = v && (!ev || ordy);
        @(posedge clk);
        if (fire) begin
            ev = 1'b1; ed = ref_pack(d, m); ec = ref_pop(m);
        end else if (ordy) begin
            ev = 1'b0;
        end
    endtask

    function automatic logic [DW-1:0] rnd_vec();
        logic [DW-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom);
        return r;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(out_valid == 1'b0, "R10 out_valid in reset", DW'(out_valid), '0);
        chk(out_data == '0, "R10 out_data in reset", out_data, '0);
        chk(out_count == '0, "R10 out_count in reset", DW'(out_count), '0);
        rst_n = 1'b1;

        // R9 corner masks
        v1 = rnd_vec();
        step("R9 zero-mask", 1'b1, v1, '0, 1'b1);
        step("R9 zero-mask", 1'b0, '0, '0, 1'b1);
        chk(ed == '0 && ec == 0, "R9 zero model", ed, '0);
        step("R9 ones-mask", 1'b1, v1, '1, 1'b1);
        step("R9 ones-mask", 1'b0, '0, '0, 1'b0);
        chk(out_data == v1 && int'(out_count) == N, "R9 all-ones passthrough", out_data, v1);
        step("R7 stall", 1'b1, rnd_vec(), 8'hA5, 1'b0);
        step("R7 stall", 1'b1, rnd_vec(), 8'h81, 1'b0);
        step("R7 drain", 1'b0, '0, '0, 1'b1);

        // R8 back-to-back with single-bit and alternating masks
        for (int k = 0; k < N; k++) step("R3 single", 1'b1, rnd_vec(), N'(1) << k, 1'b1);
        step("R2 alt", 1'b1, rnd_vec(), 8'h55, 1'b1);
        step("R2 alt", 1'b1, rnd_vec(), 8'hAA, 1'b1);
        step("R4 top", 1'b1, rnd_vec(), 8'h80, 1'b1);

        // random traffic
        for (int k = 0; k < 3000; k++)
            step("rand", 1'($urandom), rnd_vec(), N'($urandom), 1'($urandom_range(0, 3) != 0));
        for (int k = 0; k < 4; k++) step("flush", 1'b0, '0, '0, 1'b1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule